// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous host and an asynchronous, SRAM-compatible memory. It drives that memory with active-low strobes. The host gives one read or write request at a time over a ready/valid handshake. A request carries an address, write data and a per-byte mask. The block turns it into a timed sequence of chip select, write strobe, output enable and byte-lane enables. It also drives the address lines and the write data with its output-enable flag. Read data is captured into a register, and a one-cycle completion pulse marks the end of every access.

Every timing interval is a parameter in nanoseconds. Each one is turned into a whole number of system clock cycles through a clock-period parameter. Writes end on the rising edge of the write strobe, so address setup, data setup and pulse width are all measured to that edge. After the write strobe rises, the address and data stay on the pins for a recovery interval. A digital supply-good input gates all traffic. While it is low, and for a startup interval after it rises, every strobe stays inactive and no request is taken. A drop of supply-good in the middle of an access ends that access at once, and no completion pulse is given for it.

Top module: `asram_strobe_ctrl`

## Requirements
- R1: Every interval in cycles is the nanosecond value times 1000, divided by the clock period in picoseconds, rounded up, with a floor of one cycle. The write-strobe low time is the largest of the pulse-width, address-to-strobe-rise and data-setup intervals.
- R2: A read taken at clock edge k drives chip select, output enable and the masked byte enables low from edge k. The read hold time is the larger of the address-access and output-enable-access intervals. At edge k plus that time, the read port is sampled into rd_data, all strobes go high and done pulses for one cycle.
- R3: A write taken at edge k drives, from edge k, the address, the write data with mem_dq_oe high, chip select, byte enables and the write strobe, all low where active. The write strobe stays low for the interval given in R1.
- R4: After the write strobe rises, chip select, byte enables, address and write data are held for the recovery interval. Then chip select and byte enables go high, mem_dq_oe goes low and done pulses for one cycle.
- R5: Output enable stays high during the whole write access.
- R6: After chip select rises, it stays high, and ready stays low, for the larger of the minimum-high interval and the cycle interval minus the time chip select was low.
- R7: mem_be_n equals the inverted request mask, with bit 0 for the lower byte and bit 1 for the upper byte. Both lanes change only on the edge where chip select changes. A mask of zero leaves the stored word unchanged.
- R8: A request is taken only on an edge where req_valid and req_ready are both high. req_ready is high only when the block is idle and not held.
- R9: While supply-good is low, req_ready is low and all strobes are high. This also holds until supply-good has been high for the startup interval, counted in edges.
- R10: If supply-good falls during an access, all strobes go high and mem_dq_oe goes low on the next edge, and no done pulse is given.
- R11: Synchronous reset sets all strobes high and sets mem_dq_oe, done, address, write data and rd_data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply within range |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_bmask | input | DW/8 | Byte-lane select, 1 = lane used |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | DW | Captured read word |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | DW/8 | Byte-lane enables, active low |
| mem_addr | output | AW | Address to memory |
| mem_dq_out | output | DW | Write data to pad drivers |
| mem_dq_oe | output | 1 | Pad driver enable for write data |
| mem_dq_in | input | DW | Data from memory pads |

## Verification
Traffic is run against a bench-side memory that stores bytes on the rising edge of the write strobe. Every lane mask is used: full-word, upper-only and lower-only writes, then an empty-mask write, each followed by a read. The readback shows whether the lane enables map to the right bytes and whether an empty mask is really a no-op. Interval values that are not plain multiples of the clock are used, and one that is an exact multiple, so that rounding up can be told apart from truncation. Requests held during the startup lockout, reads issued back to back, and a supply drop in the middle of a read separate correct gating, spacing and abort from a sequencer that only works in the steady state.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_WREC,
    ST_GAP
  } seq_state_e;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ps);
    longint unsigned c;
    c = (64'(ns) * 64'd1000 + 64'(period_ps) - 64'd1) / 64'(period_ps);
    if (c == 64'd0) c = 64'd1;
    return c[31:0];
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_lockout.sv
module asram_lockout #(
  parameter int unsigned STARTUP_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  output logic hold
);
  localparam int LCW = $clog2(STARTUP_CYC + 1);

  logic [LCW-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst || !pwr_good)
      wait_cnt <= LCW'(STARTUP_CYC);
    else if (wait_cnt != '0)
      wait_cnt <= wait_cnt - 1'b1;
  end

  assign hold = (wait_cnt != '0) || !pwr_good;

  // R9: a supply drop keeps traffic blocked on the following cycle
  p_supply_drop_holds_r9: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> hold);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned AW       = 20,
  parameter int unsigned DW       = 16,
  parameter int unsigned NB       = 2,
  parameter int unsigned RD_CYC   = 2,
  parameter int unsigned WP_CYC   = 1,
  parameter int unsigned WREC_CYC = 1,
  parameter int unsigned GAP_RD   = 1,
  parameter int unsigned GAP_WR   = 1,
  parameter int unsigned CYC_CYC  = 2,
  parameter int unsigned CW       = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [NB-1:0] req_bmask,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [NB-1:0] mem_be_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  seq_state_e    state;
  logic [CW-1:0] cnt;

  assign req_ready = (state == ST_IDLE) && !hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      done       <= 1'b0;
      rd_data    <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_be_n   <= '1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (hold) begin
        state     <= ST_IDLE;
        cnt       <= '0;
        mem_ce_n  <= 1'b1;
        mem_we_n  <= 1'b1;
        mem_oe_n  <= 1'b1;
        mem_be_n  <= '1;
        mem_dq_oe <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (req_valid) begin
              mem_addr <= req_addr;
              mem_be_n <= ~req_bmask;
              mem_ce_n <= 1'b0;
              if (req_write) begin
                mem_we_n   <= 1'b0;
                mem_oe_n   <= 1'b1;
                mem_dq_out <= req_wdata;
                mem_dq_oe  <= 1'b1;
                cnt        <= CW'(WP_CYC - 1);
                state      <= ST_WR;
              end else begin
                mem_oe_n <= 1'b0;
                cnt      <= CW'(RD_CYC - 1);
                state    <= ST_RD;
              end
            end
          end
          ST_RD: begin
            if (cnt == '0) begin
              rd_data  <= mem_dq_in;
              done     <= 1'b1;
              mem_ce_n <= 1'b1;
              mem_oe_n <= 1'b1;
              mem_be_n <= '1;
              cnt      <= CW'(GAP_RD - 1);
              state    <= ST_GAP;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          ST_WR: begin
            if (cnt == '0) begin
              mem_we_n <= 1'b1;
              cnt      <= CW'(WREC_CYC - 1);
              state    <= ST_WREC;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          ST_WREC: begin
            if (cnt == '0) begin
              mem_ce_n  <= 1'b1;
              mem_be_n  <= '1;
              mem_dq_oe <= 1'b0;
              done      <= 1'b1;
              cnt       <= CW'(GAP_WR - 1);
              state     <= ST_GAP;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          ST_GAP: begin
            if (cnt == '0) state <= ST_IDLE;
            else           cnt   <= cnt - 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // ---------------- checker state and assertions ----------------
  logic          ce_q;
  logic [CW-1:0] since_fall;
  logic [CW-1:0] we_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q       <= 1'b1;
      since_fall <= CW'(CYC_CYC);
      we_low     <= '0;
    end else begin
      ce_q <= mem_ce_n;
      if (ce_q && !mem_ce_n)              since_fall <= CW'(1);
      else if (since_fall < CW'(CYC_CYC)) since_fall <= since_fall + 1'b1;
      if (!mem_we_n) begin
        if (we_low < CW'(WP_CYC)) we_low <= we_low + 1'b1;
      end else begin
        we_low <= '0;
      end
    end
  end

  // R6: chip-select falling edges are at least one full cycle interval apart
  p_cycle_spacing_r6: assert property (@(posedge clk) disable iff (rst)
    (ce_q && !mem_ce_n) |-> (since_fall >= CW'(CYC_CYC)));

  // R3: the write strobe is low for the full derived pulse unless aborted
  p_we_width_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_we_n) && !$past(hold)) |-> (we_low >= CW'(WP_CYC)));

  // R3: write data is on the pads whenever the write strobe is low
  p_data_driven_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe);

  // R5: the memory is never told to drive during a write
  p_oe_off_in_write_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  // R4: address does not move while chip select stays low
  p_addr_steady_r4: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  // R7: byte lanes switch only together with chip select
  p_lanes_with_ce_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(mem_be_n) |-> !$stable(mem_ce_n));

  // R2: completion follows a cycle in which the memory was selected
  p_done_after_access_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !$past(mem_ce_n));

  // R10: a hold idles every strobe on the next cycle
  p_hold_idles_r10: assert property (@(posedge clk) disable iff (rst)
    hold |=> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !done));

endmodule

// File: rtl/asram_strobe_ctrl.sv
module asram_strobe_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned AW               = 20,
  parameter int unsigned DW               = 16,
  parameter int unsigned CLK_PERIOD_PS    = 20000,
  parameter int unsigned T_CYCLE_NS       = 35,
  parameter int unsigned T_ADDR_ACC_NS    = 35,
  parameter int unsigned T_OE_ACC_NS      = 15,
  parameter int unsigned T_WE_PULSE_NS    = 15,
  parameter int unsigned T_ADDR_TO_WEH_NS = 20,
  parameter int unsigned T_DATA_SETUP_NS  = 10,
  parameter int unsigned T_WREC_NS        = 12,
  parameter int unsigned T_HIGH_NS        = 2,
  parameter int unsigned T_STARTUP_NS     = 2000000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwr_good,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_bmask,
  output logic            done,
  output logic [DW-1:0]   rd_data,
  output logic            mem_ce_n,
  output logic            mem_we_n,
  output logic            mem_oe_n,
  output logic [DW/8-1:0] mem_be_n,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_dq_out,
  output logic            mem_dq_oe,
  input  logic [DW-1:0]   mem_dq_in
);

  localparam int unsigned NB          = DW / 8;
  localparam int unsigned P           = CLK_PERIOD_PS;
  localparam int unsigned RD_CYC      = umax(ns_to_cyc(T_ADDR_ACC_NS, P), ns_to_cyc(T_OE_ACC_NS, P));
  localparam int unsigned WP_CYC      = umax(umax(ns_to_cyc(T_WE_PULSE_NS, P),
                                                  ns_to_cyc(T_ADDR_TO_WEH_NS, P)),
                                             ns_to_cyc(T_DATA_SETUP_NS, P));
  localparam int unsigned WREC_CYC    = ns_to_cyc(T_WREC_NS, P);
  localparam int unsigned HIGH_CYC    = ns_to_cyc(T_HIGH_NS, P);
  localparam int unsigned CYC_CYC     = ns_to_cyc(T_CYCLE_NS, P);
  localparam int unsigned STARTUP_CYC = ns_to_cyc(T_STARTUP_NS, P);
  localparam int unsigned WR_ACT      = WP_CYC + WREC_CYC;
  localparam int unsigned GAP_RD      = umax(HIGH_CYC, (CYC_CYC > RD_CYC) ? CYC_CYC - RD_CYC : 1);
  localparam int unsigned GAP_WR      = umax(HIGH_CYC, (CYC_CYC > WR_ACT) ? CYC_CYC - WR_ACT : 1);
  localparam int unsigned MAXC        = umax(umax(umax(RD_CYC, WP_CYC), umax(WREC_CYC, CYC_CYC)),
                                             umax(GAP_RD, GAP_WR));
  localparam int unsigned CW          = $clog2(MAXC + 1);

  logic hold;

  asram_lockout #(
    .STARTUP_CYC(STARTUP_CYC)
  ) u_lockout (
    .clk     (clk),
    .rst     (rst),
    .pwr_good(pwr_good),
    .hold    (hold)
  );

  asram_seq #(
    .AW      (AW),
    .DW      (DW),
    .NB      (NB),
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .WREC_CYC(WREC_CYC),
    .GAP_RD  (GAP_RD),
    .GAP_WR  (GAP_WR),
    .CYC_CYC (CYC_CYC),
    .CW      (CW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_bmask (req_bmask),
    .done      (done),
    .rd_data   (rd_data),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_be_n  (mem_be_n),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe),
    .mem_dq_in (mem_dq_in)
  );

endmodule

// File: tb/asram_strobe_ctrl_test.sv
module asram_strobe_ctrl_test;

  // bench-side interval arithmetic (R1), 20 ns clock
  function automatic int bcyc(input int ns);
    int c;
    c = (ns * 1000 + 19999) / 20000;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int bmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_X   = bmax(bcyc(70), bcyc(15));
  localparam int WP_X   = bmax(bmax(bcyc(45), bcyc(60)), bcyc(10));
  localparam int WREC_X = bcyc(12);
  localparam int HI_X   = bcyc(2);
  localparam int CY_X   = bcyc(150);
  localparam int LK_X   = bcyc(1000);
  localparam int GRD_X  = bmax(HI_X, (CY_X > RD_X) ? CY_X - RD_X : 1);
  localparam int GWR_X  = bmax(HI_X, (CY_X > WP_X + WREC_X) ? CY_X - WP_X - WREC_X : 1);

  logic        clk = 1'b0;
  logic        rst;
  logic        pwr_good;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_bmask;
  logic        done;
  logic [15:0] rd_data;
  logic        mem_ce_n, mem_we_n, mem_oe_n;
  logic [1:0]  mem_be_n;
  logic [19:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in;

  always #10 clk = ~clk;

  asram_strobe_ctrl #(
    .AW(20), .DW(16), .CLK_PERIOD_PS(20000),
    .T_CYCLE_NS(150), .T_ADDR_ACC_NS(70), .T_OE_ACC_NS(15),
    .T_WE_PULSE_NS(45), .T_ADDR_TO_WEH_NS(60), .T_DATA_SETUP_NS(10),
    .T_WREC_NS(12), .T_HIGH_NS(2), .T_STARTUP_NS(1000)
  ) uut (
    .clk(clk), .rst(rst), .pwr_good(pwr_good),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
    .done(done), .rd_data(rd_data),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // ---------------- behavioural memory on the far side ----------------
  logic [15:0] mem [0:255];
  initial for (int i = 0; i < 256; i++) mem[i] = {i[7:0], ~i[7:0]};
  assign mem_dq_in = mem[mem_addr[7:0]];
  always @(posedge mem_we_n) begin
    if (mem_ce_n === 1'b0) begin
      if (mem_be_n[0] === 1'b0) mem[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
      if (mem_be_n[1] === 1'b0) mem[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
    end
  end

  // ---------------- reference model: scheduled per-cycle outputs ----------------
  typedef struct packed {
    logic        ce, we, oe;
    logic [1:0]  be;
    logic [19:0] addr;
    logic        dq_oe;
    logic [15:0] dq;
    logic        done;
    logic        cap;
    logic [3:0]  tag;
  } ent_t;

  function automatic ent_t mk(input logic ce, input logic we, input logic oe, input logic [1:0] be,
                              input logic [19:0] a, input logic dqoe, input logic [15:0] d,
                              input logic dn, input logic cp, input logic [3:0] t);
    ent_t e;
    e.ce = ce; e.we = we; e.oe = oe; e.be = be; e.addr = a; e.dq_oe = dqoe;
    e.dq = d; e.done = dn; e.cap = cp; e.tag = t;
    return e;
  endfunction

  function automatic string tagname(input logic [3:0] t);
    case (t)
      4'd1: return "R9";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R6";
      4'd6: return "R10";
      4'd7: return "R11";
      default: return "R8";
    endcase
  endfunction

  ent_t        sched[$];
  ent_t        exp_e;
  logic [15:0] exp_rd;
  int          lk;
  bit          busy;

  always @(posedge clk) begin
    logic hold_m;
    logic acc;
    hold_m = (lk != 0) || !pwr_good;
    acc    = req_valid && !busy && !hold_m;
    if (rst) begin
      lk = LK_X;
      sched.delete();
      exp_e  = mk(1, 1, 1, 2'b11, 20'h0, 0, 16'h0, 0, 0, 4'd7);
      exp_rd = 16'h0;
      busy   = 0;
    end else begin
      if (!pwr_good) lk = LK_X;
      else if (lk > 0) lk--;
      if (hold_m) begin
        exp_e = mk(1, 1, 1, 2'b11, exp_e.addr, 0, exp_e.dq, 0, 0, busy ? 4'd6 : 4'd1);
        sched.delete();
        busy = 0;
      end else if (sched.size() != 0) begin
        exp_e = sched.pop_front();
        busy  = 1;
        if (exp_e.cap) exp_rd = mem[exp_e.addr[7:0]];
      end else if (acc) begin
        if (req_write) begin
          for (int i = 0; i < WP_X; i++)
            sched.push_back(mk(0, 0, 1, ~req_bmask, req_addr, 1, req_wdata, 0, 0, 4'd3));
          for (int i = 0; i < WREC_X; i++)
            sched.push_back(mk(0, 1, 1, ~req_bmask, req_addr, 1, req_wdata, 0, 0, 4'd4));
          for (int i = 0; i < GWR_X; i++)
            sched.push_back(mk(1, 1, 1, 2'b11, req_addr, 0, req_wdata, i == 0, 0, 4'd5));
        end else begin
          for (int i = 0; i < RD_X; i++)
            sched.push_back(mk(0, 1, 0, ~req_bmask, req_addr, 0, exp_e.dq, 0, 0, 4'd2));
          for (int i = 0; i < GRD_X; i++)
            sched.push_back(mk(1, 1, 1, 2'b11, req_addr, 0, exp_e.dq, i == 0, i == 0, 4'd5));
        end
        exp_e = sched.pop_front();
        busy  = 1;
      end else begin
        exp_e = mk(1, 1, 1, 2'b11, exp_e.addr, 0, exp_e.dq, 0, 0, 4'd0);
        busy  = 0;
      end
    end
  end

  // ---------------- per-clock comparison ----------------
  int vectors = 0;
  int miscompares = 0;
  int done_cnt = 0;
  int we_run = 0;

  always @(posedge clk) begin
    logic [44:0] act_v, exp_v;
    logic        exp_ready;
    #2;
    exp_ready = !busy && (lk == 0) && pwr_good;
    act_v = {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_addr, mem_dq_oe, mem_dq_out, done};
    exp_v = {exp_e.ce, exp_e.we, exp_e.oe, exp_e.be, exp_e.addr, exp_e.dq_oe, exp_e.dq, exp_e.done};
    vectors++;
    if (act_v !== exp_v || rd_data !== exp_rd || req_ready !== exp_ready) begin
      miscompares++;
      $display("FAIL %s pins: actual %h rd %h rdy %b, expected %h rd %h rdy %b",
               tagname(exp_e.tag), act_v, rd_data, req_ready, exp_v, exp_rd, exp_ready);
    end
    if (done === 1'b1) done_cnt++;
    // R5: output enable must be high whenever the write strobe is low
    if (mem_we_n === 1'b0) begin
      vectors++;
      if (mem_oe_n !== 1'b1) begin
        miscompares++;
        $display("FAIL R5 oe during write: actual %b expected 1", mem_oe_n);
      end
      we_run++;
    end else if (we_run > 0) begin
      // R1: strobe low time equals the rounded-up derived interval
      vectors++;
      if (we_run != WP_X) begin
        miscompares++;
        $display("FAIL R1 write strobe width: actual %0d expected %0d", we_run, WP_X);
      end
      we_run = 0;
    end
  end

  // ---------------- stimulus ----------------
  task automatic request(input logic w, input logic [19:0] a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_bmask = m;
    while (req_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (req_ready !== 1'b1) @(negedge clk);
  endtask

  task automatic check_rd(input logic [15:0] want, input string tag);
    vectors++;
    if (rd_data !== want) begin
      miscompares++;
      $display("FAIL %s readback: actual %h expected %h", tag, rd_data, want);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    int d0;
    rst = 1'b1; pwr_good = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_bmask = '0;
    repeat (3) @(negedge clk);
    // R11: reset state at the ports
    vectors++;
    if ({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe, done, req_ready, rd_data} !== {7'b1111100, 1'b0, 16'h0}) begin
      miscompares++;
      $display("FAIL R11 reset state: actual %b%b%b%b%b%b%b %h expected 1111100 0000",
               mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe, done, req_ready, rd_data);
    end
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R9: a request held through the startup lockout waits for it to end
    pwr_good = 1'b1;
    request(1'b0, 20'h00012, 16'h0, 2'b11);
    wait_idle();
    check_rd(16'h12ED, "R2");

    // R7: lane masks against the far-side memory
    request(1'b1, 20'h000A5, 16'h1234, 2'b11);
    request(1'b0, 20'h000A5, 16'h0, 2'b11);
    wait_idle();
    check_rd(16'h1234, "R7");
    request(1'b1, 20'h000A5, 16'hBEEF, 2'b10);
    request(1'b0, 20'h000A5, 16'h0, 2'b11);
    wait_idle();
    check_rd(16'hBE34, "R7");
    request(1'b1, 20'h000A5, 16'h0077, 2'b01);
    request(1'b0, 20'h000A5, 16'h0, 2'b11);
    wait_idle();
    check_rd(16'hBE77, "R7");
    request(1'b1, 20'h000A5, 16'hFFFF, 2'b00);
    request(1'b0, 20'h000A5, 16'h0, 2'b11);
    wait_idle();
    check_rd(16'hBE77, "R7");

    // R6/R8: back-to-back traffic with high address bits set
    request(1'b0, 20'hFFF33, 16'h0, 2'b11);
    request(1'b0, 20'h80044, 16'h0, 2'b01);
    request(1'b1, 20'h7FF10, 16'hC3C3, 2'b11);
    request(1'b0, 20'h00010, 16'h0, 2'b11);
    wait_idle();
    check_rd(16'hC3C3, "R6");

    // R10: supply drop in the middle of a read
    d0 = done_cnt;
    request(1'b0, 20'h00020, 16'h0, 2'b11);
    pwr_good = 1'b0;
    repeat (RD_X + GRD_X + 2) @(negedge clk);
    vectors++;
    if (done_cnt != d0) begin
      miscompares++;
      $display("FAIL R10 done after abort: actual %0d expected %0d", done_cnt - d0, 0);
    end
    pwr_good = 1'b1;
    request(1'b0, 20'h00021, 16'h0, 2'b11);
    wait_idle();
    check_rd(16'h21DE, "R9");
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    finish_run();
  end

endmodule